// File: doc/BRIEF.md
# Two-Byte Parallel DAC Load Sequencer

This block moves one 12-bit sample into a double-buffered DAC over an 8-bit parallel bus. A host presents the sample with a one-cycle start strobe. The block captures the sample and optionally pulses the DAC's clear line, so the analog output passes through zero. It then places the upper four sample bits on the bus with the byte-select line high, which loads the high-byte input register. Next it drops byte-select and places the lower eight bits on the bus, which latches the high byte and selects the low-byte input register. A final active-low chip-enable pulse copies both input registers into the DAC output register.

Every phase lasts a programmable number of clock cycles, so the bus setup and hold times of a slow converter can be met from a fast system clock. The host sees a busy flag for the whole update and a one-cycle done pulse at the end. The bus keeps its last value between updates.

Top module: `dac_word_loader`

## Requirements
- R1: While idle and after reset, the clear and chip-enable lines are high, byte-select is low, busy and done are low, and the data bus reads 0x00.
- R2: While byte-select is high, the bus carries the high byte. Bus bits 3..0 hold sample bits 11..8, and bus bits 7..4 are zero.
- R3: While chip-enable is low, the bus carries sample bits 7..0 unchanged.
- R4: With the clear-skip input low, an update first drives clear low for N cycles and then high for N cycles, before byte-select rises.
- R5: With the clear-skip input high, clear stays high for the whole update, and byte-select rises in the first cycle after acceptance.
- R6: Each update has exactly one byte-select high period, lasting N cycles. Clear and chip-enable are both high throughout it.
- R7: Chip-enable goes low for exactly N cycles, only after byte-select has fallen. While chip-enable is low, clear is high and byte-select is low.
- R8: N is the hold-length input sampled when start is accepted. A value of 0 acts as 1, and changes to the hold-length input during an update have no effect on it.
- R9: Busy rises in the cycle after start is accepted and stays high for 5·N cycles, or 3·N cycles when the clear is skipped. A start seen while busy is ignored. Sample, clear-skip and hold-length changes made during an update do not alter it.
- R10: Done is high for exactly one cycle per update. That cycle is the first one with chip-enable back high, and busy is low in it.
- R11: After an update the bus keeps the low byte until the next update's high-byte phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Start strobe, accepted when not busy |
| sample | input | 12 | Sample to convert |
| skip_clear | input | 1 | 1 = omit the clear pulse |
| hold_cycles | input | 8 | Cycles per phase (0 treated as 1) |
| busy | output | 1 | Update in progress |
| done | output | 1 | One-cycle completion pulse |
| dac_bus | output | 8 | Parallel data to the DAC |
| dac_clr_n | output | 1 | Active-low clear to the DAC |
| dac_ce_n | output | 1 | Active-low chip-enable, rising edge loads the output register |
| dac_bsel | output | 1 | Byte select: 1 = high-byte register, 0 = low-byte register |

## Verification
The bench targets the points where a byte-sequencing error would corrupt the converted value. It checks nibble placement of the high byte: a design that shifted the nibble, or left stray upper bits, would load a wrong MSB. It checks the order of the phases: a chip-enable pulse before byte-select falls would transfer a half-written word. It checks the zero hold length, where an off-by-one counter would stretch or collapse the phases. It also injects a second start, a new sample, a new hold length and a flipped clear-skip in the middle of an update. A design that accepted that start, or read its inputs live, would show a wrong busy length or wrong bus data.

// File: rtl/dac_loader_pkg.sv
package dac_loader_pkg;
  localparam int SAMPLE_W = 12;
  localparam int BUS_W    = 8;
  localparam int HI_W     = SAMPLE_W - BUS_W;

  typedef enum logic [2:0] {
    PH_IDLE    = 3'd0,
    PH_CLR_LO  = 3'd1,
    PH_CLR_HI  = 3'd2,
    PH_HI_BYTE = 3'd3,
    PH_LO_BYTE = 3'd4,
    PH_CE_LO   = 3'd5
  } phase_e;

  // High byte: sample MSBs right-aligned, zeros above.
  function automatic logic [BUS_W-1:0] high_byte(input logic [SAMPLE_W-1:0] s);
    return {{(BUS_W-HI_W){1'b0}}, s[SAMPLE_W-1:BUS_W]};
  endfunction

  function automatic logic [BUS_W-1:0] low_byte(input logic [SAMPLE_W-1:0] s);
    return s[BUS_W-1:0];
  endfunction
endpackage

// File: rtl/dac_phase_timer.sv
module dac_phase_timer #(
  parameter int HOLD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [HOLD_W-1:0] len,
  output logic              expire
);
  localparam logic [HOLD_W-1:0] ONE = {{(HOLD_W-1){1'b0}}, 1'b1};

  logic [HOLD_W-1:0] cnt;

  // A phase of len cycles starts at len-1; zero length behaves as one.
  function automatic logic [HOLD_W-1:0] first_count(input logic [HOLD_W-1:0] l);
    return (l == '0) ? '0 : l - ONE;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= first_count(len);
    else if (cnt != '0)  cnt <= cnt - ONE;
  end

  assign expire = (cnt == '0);
endmodule

// File: rtl/dac_load_fsm.sv
module dac_load_fsm
  import dac_loader_pkg::*;
#(
  parameter int HOLD_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [SAMPLE_W-1:0] sample,
  input  logic                skip_clear,
  input  logic [HOLD_W-1:0]   hold_cycles,
  input  logic                expire,
  output phase_e              phase,
  output logic [SAMPLE_W-1:0] sample_q,
  output logic                timer_load,
  output logic [HOLD_W-1:0]   timer_len,
  output logic                accept,
  output logic                phase_end,
  output logic                done
);
  phase_e            phase_n;
  logic [HOLD_W-1:0] hold_q;

  assign accept    = start && (phase == PH_IDLE);
  assign phase_end = (phase != PH_IDLE) && expire;

  always_comb begin
    phase_n = phase;
    if (accept) begin
      phase_n = skip_clear ? PH_HI_BYTE : PH_CLR_LO;
    end else if (phase_end) begin
      unique case (phase)
        PH_CLR_LO:  phase_n = PH_CLR_HI;
        PH_CLR_HI:  phase_n = PH_HI_BYTE;
        PH_HI_BYTE: phase_n = PH_LO_BYTE;
        PH_LO_BYTE: phase_n = PH_CE_LO;
        PH_CE_LO:   phase_n = PH_IDLE;
        default:    phase_n = PH_IDLE;
      endcase
    end
  end

  assign timer_load = accept || (phase_end && phase != PH_CE_LO);
  assign timer_len  = accept ? hold_cycles : hold_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase    <= PH_IDLE;
      hold_q   <= '0;
      sample_q <= '0;
      done     <= 1'b0;
    end else begin
      phase <= phase_n;
      done  <= phase_end && (phase == PH_CE_LO);
      if (accept) begin
        hold_q   <= hold_cycles;
        sample_q <= sample;
      end
    end
  end
endmodule

// File: rtl/dac_bus_driver.sv
module dac_bus_driver
  import dac_loader_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  phase_e              phase,
  input  logic [SAMPLE_W-1:0] sample_q,
  output logic [BUS_W-1:0]    bus,
  output logic                clr_n,
  output logic                ce_n,
  output logic                bsel,
  output logic                busy
);
  logic [BUS_W-1:0] bus_q;

  always_comb begin
    unique case (phase)
      PH_HI_BYTE: bus = high_byte(sample_q);
      PH_LO_BYTE: bus = low_byte(sample_q);
      default:    bus = bus_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) bus_q <= '0;
    else        bus_q <= bus;
  end

  assign clr_n = (phase != PH_CLR_LO);
  assign ce_n  = (phase != PH_CE_LO);
  assign bsel  = (phase == PH_HI_BYTE);
  assign busy  = (phase != PH_IDLE);
endmodule

// File: rtl/dac_word_loader.sv
module dac_word_loader
  import dac_loader_pkg::*;
#(
  parameter int HOLD_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [SAMPLE_W-1:0] sample,
  input  logic                skip_clear,
  input  logic [HOLD_W-1:0]   hold_cycles,
  output logic                busy,
  output logic                done,
  output logic [BUS_W-1:0]    dac_bus,
  output logic                dac_clr_n,
  output logic                dac_ce_n,
  output logic                dac_bsel
);
  phase_e              phase;
  logic [SAMPLE_W-1:0] sample_q;
  logic                timer_load;
  logic [HOLD_W-1:0]   timer_len;
  logic                timer_expire;
  logic                accept_evt;
  logic                phase_end_evt;

  dac_phase_timer #(.HOLD_W(HOLD_W)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (timer_load),
    .len    (timer_len),
    .expire (timer_expire)
  );

  dac_load_fsm #(.HOLD_W(HOLD_W)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .sample      (sample),
    .skip_clear  (skip_clear),
    .hold_cycles (hold_cycles),
    .expire      (timer_expire),
    .phase       (phase),
    .sample_q    (sample_q),
    .timer_load  (timer_load),
    .timer_len   (timer_len),
    .accept      (accept_evt),
    .phase_end   (phase_end_evt),
    .done        (done)
  );

  dac_bus_driver u_drv (
    .clk      (clk),
    .rst_n    (rst_n),
    .phase    (phase),
    .sample_q (sample_q),
    .bus      (dac_bus),
    .clr_n    (dac_clr_n),
    .ce_n     (dac_ce_n),
    .bsel     (dac_bsel),
    .busy     (busy)
  );
endmodule

// File: rtl/dac_loader_checks.sv
module dac_loader_checks
  import dac_loader_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             busy,
  input logic             done,
  input logic [BUS_W-1:0] dac_bus,
  input logic             dac_clr_n,
  input logic             dac_ce_n,
  input logic             dac_bsel,
  input logic             accept_evt,
  input logic             phase_end_evt
);
  assert_idle_lines_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (dac_clr_n && dac_ce_n && !dac_bsel));

  assert_hi_upper_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    dac_bsel |-> (dac_bus[BUS_W-1:BUS_W-HI_W] == '0));

  assert_bsel_alone_R6: assert property (@(posedge clk) disable iff (!rst_n)
    dac_bsel |-> (dac_clr_n && dac_ce_n && busy));

  assert_ce_alone_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !dac_ce_n |-> (dac_clr_n && !dac_bsel && busy));

  assert_accept_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    accept_evt |=> busy);

  assert_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (start && busy) |-> !accept_evt);

  assert_phase_end_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    phase_end_evt |-> busy);

  assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_after_ce_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (dac_ce_n && !busy && !$past(dac_ce_n)));

  assert_bus_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && $past(!busy)) |-> $stable(dac_bus));
endmodule

bind dac_word_loader dac_loader_checks u_checks (
  .clk           (clk),
  .rst_n         (rst_n),
  .start         (start),
  .busy          (busy),
  .done          (done),
  .dac_bus       (dac_bus),
  .dac_clr_n     (dac_clr_n),
  .dac_ce_n      (dac_ce_n),
  .dac_bsel      (dac_bsel),
  .accept_evt    (accept_evt),
  .phase_end_evt (phase_end_evt)
);

// File: tb/dac_word_loader_test.sv
`timescale 1ns/1ps
module dac_word_loader_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [11:0] sample_i = '0;
  logic        skip_i = 1'b0;
  logic [7:0]  hold_i = 8'd1;
  logic        busy_o, done_o, clr_n_o, ce_n_o, bsel_o;
  logic [7:0]  bus_o;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  dac_word_loader uut (
    .clk (clk), .rst_n (rst_n), .start (start_i), .sample (sample_i),
    .skip_clear (skip_i), .hold_cycles (hold_i), .busy (busy_o), .done (done_o),
    .dac_bus (bus_o), .dac_clr_n (clr_n_o), .dac_ce_n (ce_n_o), .dac_bsel (bsel_o)
  );

  // {sample, skip_clear, hold}
  localparam logic [20:0] VECS [0:5] = '{
    {12'hA5C, 1'b0, 8'd1},
    {12'hFFF, 1'b0, 8'd3},
    {12'h000, 1'b1, 8'd2},
    {12'h80F, 1'b1, 8'd1},
    {12'h123, 1'b0, 8'd0},
    {12'h7E1, 1'b0, 8'd4}
  };

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  task automatic check_idle(input string req, input int exp_bus);
    check(clr_n_o == 1'b1, req, "clr_n idle", int'(clr_n_o), 1);
    check(ce_n_o == 1'b1, req, "ce_n idle", int'(ce_n_o), 1);
    check(bsel_o == 1'b0, req, "bsel idle", int'(bsel_o), 0);
    check(busy_o == 1'b0, req, "busy idle", int'(busy_o), 0);
    check(done_o == 1'b0, req, "done idle", int'(done_o), 0);
    check(int'(bus_o) == exp_bus, req, "bus idle", int'(bus_o), exp_bus);
  endtask

  task automatic run_update(input logic [11:0] s, input logic skip,
                            input logic [7:0] hold, input bit intrude);
    int n, exp_busy, exp_clr;
    int busy_n, clr_lo, bsel_n, bsel_rises, ce_lo, done_n;
    bit order_bad, hi_bad, lo_bad, ce_early, done_ok, got_done, first_bsel_ok;
    logic prev_bsel, prev_ce, orig_skip;
    logic [7:0] exp_hi, exp_lo;
    n = (hold == 0) ? 1 : int'(hold);
    exp_busy = (skip ? 3 : 5) * n;
    exp_clr = skip ? 0 : n;
    exp_hi = {4'h0, s[11:8]};
    exp_lo = s[7:0];
    busy_n = 0; clr_lo = 0; bsel_n = 0; bsel_rises = 0; ce_lo = 0; done_n = 0;
    order_bad = 0; hi_bad = 0; lo_bad = 0; ce_early = 0; done_ok = 0; got_done = 0;
    first_bsel_ok = 0; prev_bsel = 0; prev_ce = 1; orig_skip = skip;

    @(negedge clk);
    sample_i = s; skip_i = skip; hold_i = hold; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    for (int c = 0; c < 4000 && !got_done; c++) begin
      if (intrude && c == 2) begin
        start_i = 1'b1; sample_i = 12'h5A5; hold_i = 8'd9; skip_i = ~orig_skip;
      end else if (intrude && c == 3) begin
        start_i = 1'b0;
      end
      busy_n += int'(busy_o);
      if (!clr_n_o) begin
        clr_lo++;
        if (bsel_n != 0) order_bad = 1;
      end
      if (bsel_o) begin
        if (!prev_bsel) begin
          bsel_rises++;
          if (c == (skip ? 0 : 2 * n)) first_bsel_ok = 1;
        end
        bsel_n++;
        if (bus_o != exp_hi) hi_bad = 1;
        if (clr_lo != exp_clr) order_bad = 1;
      end
      if (!ce_n_o) begin
        ce_lo++;
        if (bus_o != exp_lo) lo_bad = 1;
        if (bsel_n != n || bsel_o) ce_early = 1;
      end
      if (done_o) begin
        done_n++;
        done_ok = ce_n_o && !busy_o && !prev_ce;
        got_done = 1;
      end
      prev_bsel = bsel_o;
      prev_ce = ce_n_o;
      if (!got_done) @(negedge clk);
    end
    check(busy_n == exp_busy, "R9", "busy length", busy_n, exp_busy);
    check(clr_lo == exp_clr, skip ? "R5" : "R4", "clear low cycles", clr_lo, exp_clr);
    check(!order_bad, "R4", "clear before byte select", int'(order_bad), 0);
    check(first_bsel_ok, skip ? "R5" : "R4", "byte select start cycle", int'(first_bsel_ok), 1);
    check(bsel_rises == 1, "R6", "byte select periods", bsel_rises, 1);
    check(bsel_n == n, "R8", "byte select length", bsel_n, n);
    check(!hi_bad, "R2", "high byte on bus", int'(hi_bad), 0);
    check(!lo_bad, "R3", "low byte on bus", int'(lo_bad), 0);
    check(ce_lo == n, "R7", "chip-enable low cycles", ce_lo, n);
    check(!ce_early, "R7", "chip-enable after byte select", int'(ce_early), 0);
    check(got_done && done_ok, "R10", "done placement", int'(done_ok), 1);
    @(negedge clk);
    check(done_o == 1'b0, "R10", "done width", int'(done_o), 0);
    for (int k = 0; k < 6; k++) @(negedge clk);
    check(busy_o == 1'b0, "R9", "no extra update", int'(busy_o), 0);
    check(bus_o == exp_lo, "R11", "bus holds low byte", int'(bus_o), int'(exp_lo));
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 150000);
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_idle("R1", 0);

    for (int v = 0; v < 6; v++) begin
      run_update(VECS[v][20:9], VECS[v][8], VECS[v][7:0], 1'b0);
    end

    // Start, sample, skip and hold changes during an update are ignored.
    run_update(12'hC39, 1'b0, 8'd2, 1'b1);
    run_update(12'h3C6, 1'b1, 8'd3, 1'b1);

    // Reset in the middle of an update returns all lines to idle.
    @(negedge clk);
    sample_i = 12'hBEE; skip_i = 1'b0; hold_i = 8'd4; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (10) @(negedge clk);
    check(bsel_o == 1'b1, "R6", "byte select mid-update", int'(bsel_o), 1);
    rst_n = 1'b0;
    @(negedge clk);
    check_idle("R1", 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check_idle("R1", 0);

    summary();
  end
endmodule